// File: doc/BRIEF.md
# Disc address validation unit

This block sits between a drive's internal command decoder and its cylinder, head and sector address registers. All three addresses arrive on one shared control data bus. The decoder raises a strobe for each command. On the leading edge of each strobe the block compares the relevant bus field against its legal range. It loads the field into its register only when the value is in range.

Out-of-range values leave the register unchanged and set a sticky error flag. A seek is also flagged when it is issued while the heads are still moving. The flags clear on power-on start, on the run switch, on a clear command, and (for the seek flag only) on seek-home or a clean legal seek. The flags and the three register contents are presented as outputs for the controller to read.

Top module: `disc_addr_validator`

## Requirements
- R1: After a synchronous active-low reset, the cylinder, head and sector registers read 0 and all status flags read 0.
- R2: On the cycle where `seek_cmd` goes from 0 to 1, the cylinder field `bus_data[9:0]` is loaded into `cyl_addr` if it is at most 822. A value of 823 or more leaves `cyl_addr` unchanged.
- R3: A seek leading edge with a cylinder field above 822 sets the seek-check flag.
- R4: A seek leading edge while `access_ready` is 0 sets the seek-check flag, even when the cylinder value is legal.
- R5: The seek-check flag clears on a seek leading edge with a legal cylinder while `access_ready` is 1. It also clears on every cycle in which `home_cmd` is 1.
- R6: On an `adr_cmd` leading edge, the head field `bus_data[11:8]` is loaded into `head_addr` if it is at most 8. A value of 9 or more leaves `head_addr` unchanged and sets the illegal-head flag.
- R7: On an `adr_cmd` or `xms_cmd` leading edge, the sector field `bus_data[7:0]` is loaded into `sector_addr` if it is at most 63. A value of 64 or more leaves `sector_addr` unchanged and sets the illegal-sector flag. An `xms_cmd` edge never changes `head_addr`.
- R8: The illegal-head and illegal-sector flags are sticky. A later legal address does not clear them. Only `por_start` = 1, `run_on` = 1, or a `cps_cmd` leading edge clears them.
- R9: A clear condition that occurs in the same cycle as a set condition wins, so the flag reads 0 afterwards.
- R10: Only the 0-to-1 transition of a command strobe acts. Holding a strobe high while the bus changes loads nothing and sets no flag.
- R11: `fault_flags` bit 0 is seek-check, bit 1 is illegal-head, and bit 2 is illegal-sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_data | input | 12 | Shared control data bus |
| seek_cmd | input | 1 | Decoded seek strobe |
| adr_cmd | input | 1 | Decoded head/sector address strobe |
| xms_cmd | input | 1 | Decoded sector-only address strobe |
| cps_cmd | input | 1 | Decoded flag-clear strobe |
| home_cmd | input | 1 | Seek-home active (level) |
| por_start | input | 1 | Power-on sequence start (level) |
| run_on | input | 1 | Run switch asserted (level) |
| access_ready | input | 1 | Heads settled; 0 means heads in motion |
| cyl_addr | output | 10 | Cylinder register |
| head_addr | output | 4 | Head register |
| sector_addr | output | 8 | Sector register |
| fault_flags | output | 3 | Sticky status flags |

## Verification
The hardest situation to reach is a clear and a set condition landing in the very same cycle. One example is a CPS edge together with an illegal-head ADR edge. Another is the run switch together with an illegal seek. Random stimulus rarely produces these, so directed steps raise both strobes on one negative edge.

The stimulus also holds a strobe high across a bus change, to show that only leading edges act. Random phases bias bus values around 822, 8 and 63, toggle `access_ready`, and keep clear inputs rare. The flags therefore have time to accumulate between clears.

// File: rtl/dav_pkg.sv
// Package: shared indices for the disc address validation unit.
// Assumes a single clock domain for all users.
package dav_pkg;
    // Command strobe lanes fed to the edge detector
    localparam int CMD_SEEK  = 0;
    localparam int CMD_ADR   = 1;
    localparam int CMD_XMS   = 2;
    localparam int CMD_CPS   = 3;
    localparam int NUM_CMDS  = 4;

    // Bit positions in the status vector
    localparam int FLAG_SEEK = 0;
    localparam int FLAG_HEAD = 1;
    localparam int FLAG_SECT = 2;
    localparam int NUM_FLAGS = 3;
endpackage

// File: rtl/dav_cmd_edge.sv
// Module: leading-edge detector for a vector of decoded command strobes.
// Assumes strobes are synchronous to clk; rise[i] is high for the one cycle
// in which strobe[i] is 1 and was 0 on the previous cycle.
module dav_cmd_edge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strobe,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_lane
        // Remember last cycle's strobe level for this lane
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= strobe[i];
        end

        // Leading edge: high now, low one cycle ago
        always_comb rise[i] = strobe[i] & ~prev_q[i];

        // R10: an edge pulse never lasts two cycles
        p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
            rise[i] |=> !rise[i]);
    end
endmodule

// File: rtl/dav_range_gate.sv
// Module: range comparator plus address register with gated load.
// Assumes MAX fits in W bits. The register takes din only on a load request
// whose value is at most MAX; illegal reports the comparison combinationally.
module dav_range_gate #(
    parameter int W   = 10,
    parameter int MAX = 822
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         ld_req,
    output logic         illegal,
    output logic [W-1:0] q
);
    localparam logic [W:0] LIMIT = (W+1)'(MAX);

    // Compare the field against its inclusive upper bound
    always_comb illegal = ({1'b0, din} > LIMIT);

    // Address register: load only legal values on a request
    always_ff @(posedge clk) begin
        if (!rst_n)                  q <= '0;
        else if (ld_req && !illegal) q <= din;
    end

    // R2/R6/R7: illegal values never reach the register
    p_block_illegal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && illegal) |=> $stable(q));

    // R2/R6/R7: legal values are captured on the request
    p_take_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !illegal) |=> (q == $past(din)));

    // R10: without a request the register keeps its value
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_req |=> $stable(q));
endmodule

// File: rtl/dav_flag_unit.sv
// Module: sticky seek-check, illegal-head and illegal-sector flags.
// Assumes all command inputs are single-cycle leading-edge pulses.
// Priority in each flag: hard clear, then set, then soft clear.
module dav_flag_unit
    import dav_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hard_clr,
    input  logic                 home_hold,
    input  logic                 seek_rise,
    input  logic                 adr_rise,
    input  logic                 xms_rise,
    input  logic                 cyl_bad,
    input  logic                 head_bad,
    input  logic                 sec_bad,
    input  logic                 ready,
    output logic [NUM_FLAGS-1:0] flags
);
    logic sc_clr, sc_set, sc_soft_clr;
    logic ih_set, is_set;

    // Seek-check conditions
    always_comb begin
        sc_clr      = hard_clr | home_hold;
        sc_set      = seek_rise & (cyl_bad | ~ready);
        sc_soft_clr = seek_rise & ~cyl_bad & ready;
    end

    // Head and sector set conditions
    always_comb begin
        ih_set = adr_rise & head_bad;
        is_set = (adr_rise | xms_rise) & sec_bad;
    end

    // Seek-check flip-flop
    always_ff @(posedge clk) begin
        if (!rst_n)           flags[FLAG_SEEK] <= 1'b0;
        else if (sc_clr)      flags[FLAG_SEEK] <= 1'b0;
        else if (sc_set)      flags[FLAG_SEEK] <= 1'b1;
        else if (sc_soft_clr) flags[FLAG_SEEK] <= 1'b0;
    end

    // Illegal-head flip-flop
    always_ff @(posedge clk) begin
        if (!rst_n)        flags[FLAG_HEAD] <= 1'b0;
        else if (hard_clr) flags[FLAG_HEAD] <= 1'b0;
        else if (ih_set)   flags[FLAG_HEAD] <= 1'b1;
    end

    // Illegal-sector flip-flop
    always_ff @(posedge clk) begin
        if (!rst_n)        flags[FLAG_SECT] <= 1'b0;
        else if (hard_clr) flags[FLAG_SECT] <= 1'b0;
        else if (is_set)   flags[FLAG_SECT] <= 1'b1;
    end

    // R9: a hard clear leaves all flags low, whatever else happens
    p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hard_clr |=> (flags == '0));

    // R3: an illegal-cylinder seek sets seek-check
    p_bad_cyl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seek_rise && cyl_bad && !hard_clr && !home_hold) |=> flags[FLAG_SEEK]);

    // R4: a seek while heads move sets seek-check
    p_busy_seek_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seek_rise && !ready && !hard_clr && !home_hold) |=> flags[FLAG_SEEK]);

    // R5: seek-home drops the seek-check flag
    p_home_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        home_hold |=> !flags[FLAG_SEEK]);

    // R6: illegal head on an address strobe sets its flag
    p_bad_head_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adr_rise && head_bad && !hard_clr) |=> flags[FLAG_HEAD]);

    // R8: head and sector flags only fall on a hard clear
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hard_clr && flags[FLAG_HEAD]) |=> flags[FLAG_HEAD]);
    p_sticky_sec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hard_clr && flags[FLAG_SECT]) |=> flags[FLAG_SECT]);
endmodule

// File: rtl/disc_addr_validator.sv
// Module: top of the disc address validation unit.
// Splits the shared bus into cylinder, head and sector fields. Detects command
// leading edges, gates each address register by its range check and keeps
// the sticky fault flags. Assumes all inputs share the clk domain.
module disc_addr_validator
    import dav_pkg::*;
#(
    parameter int BUS_W    = 12,
    parameter int CYL_W    = 10,
    parameter int CYL_LSB  = 0,
    parameter int CYL_MAX  = 822,
    parameter int HEAD_W   = 4,
    parameter int HEAD_LSB = 8,
    parameter int HEAD_MAX = 8,
    parameter int SEC_W    = 8,
    parameter int SEC_LSB  = 0,
    parameter int SEC_MAX  = 63
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BUS_W-1:0]     bus_data,
    input  logic                 seek_cmd,
    input  logic                 adr_cmd,
    input  logic                 xms_cmd,
    input  logic                 cps_cmd,
    input  logic                 home_cmd,
    input  logic                 por_start,
    input  logic                 run_on,
    input  logic                 access_ready,
    output logic [CYL_W-1:0]     cyl_addr,
    output logic [HEAD_W-1:0]    head_addr,
    output logic [SEC_W-1:0]     sector_addr,
    output logic [NUM_FLAGS-1:0] fault_flags
);
    localparam int CYL_MSB  = CYL_LSB + CYL_W - 1;
    localparam int HEAD_MSB = HEAD_LSB + HEAD_W - 1;
    localparam int SEC_MSB  = SEC_LSB + SEC_W - 1;

    logic [NUM_CMDS-1:0] strobes;
    logic [NUM_CMDS-1:0] rises;
    logic                cyl_bad, head_bad, sec_bad;
    logic                hard_clr;
    logic                sec_ld;

    // Gather command strobes into one vector for edge detection
    always_comb begin
        strobes           = '0;
        strobes[CMD_SEEK] = seek_cmd;
        strobes[CMD_ADR]  = adr_cmd;
        strobes[CMD_XMS]  = xms_cmd;
        strobes[CMD_CPS]  = cps_cmd;
    end

    dav_cmd_edge #(.N(NUM_CMDS)) i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobes),
        .rise   (rises)
    );

    // Clear events common to all flags; sector load on either address strobe
    always_comb begin
        hard_clr = por_start | run_on | rises[CMD_CPS];
        sec_ld   = rises[CMD_ADR] | rises[CMD_XMS];
    end

    dav_range_gate #(.W(CYL_W), .MAX(CYL_MAX)) i_cyl (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (bus_data[CYL_MSB:CYL_LSB]),
        .ld_req  (rises[CMD_SEEK]),
        .illegal (cyl_bad),
        .q       (cyl_addr)
    );

    dav_range_gate #(.W(HEAD_W), .MAX(HEAD_MAX)) i_head (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (bus_data[HEAD_MSB:HEAD_LSB]),
        .ld_req  (rises[CMD_ADR]),
        .illegal (head_bad),
        .q       (head_addr)
    );

    dav_range_gate #(.W(SEC_W), .MAX(SEC_MAX)) i_sec (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (bus_data[SEC_MSB:SEC_LSB]),
        .ld_req  (sec_ld),
        .illegal (sec_bad),
        .q       (sector_addr)
    );

    dav_flag_unit i_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .hard_clr  (hard_clr),
        .home_hold (home_cmd),
        .seek_rise (rises[CMD_SEEK]),
        .adr_rise  (rises[CMD_ADR]),
        .xms_rise  (rises[CMD_XMS]),
        .cyl_bad   (cyl_bad),
        .head_bad  (head_bad),
        .sec_bad   (sec_bad),
        .ready     (access_ready),
        .flags     (fault_flags)
    );

    // R7: a sector-only strobe leaves the head register alone
    p_xms_keeps_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xms_cmd && !adr_cmd) |=> $stable(head_addr));

    // R10: a held seek strobe changes nothing in the cylinder register
    p_held_seek_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seek_cmd && $past(seek_cmd)) |=> $stable(cyl_addr));
endmodule

// File: tb/test_disc_addr_validator.sv
module test_disc_addr_validator;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] bus_data;
    logic        seek_cmd, adr_cmd, xms_cmd, cps_cmd;
    logic        home_cmd, por_start, run_on, access_ready;
    logic [9:0]  cyl_addr;
    logic [3:0]  head_addr;
    logic [7:0]  sector_addr;
    logic [2:0]  fault_flags;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference state
    logic [9:0] m_cyl;
    logic [3:0] m_head;
    logic [7:0] m_sec;
    logic [2:0] m_flg;
    logic       p_seek, p_adr, p_xms, p_cps;

    always #5 clk = ~clk;

    disc_addr_validator i_disc_addr_validator (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data),
        .seek_cmd(seek_cmd), .adr_cmd(adr_cmd), .xms_cmd(xms_cmd),
        .cps_cmd(cps_cmd), .home_cmd(home_cmd), .por_start(por_start),
        .run_on(run_on), .access_ready(access_ready),
        .cyl_addr(cyl_addr), .head_addr(head_addr),
        .sector_addr(sector_addr), .fault_flags(fault_flags)
    );

    function automatic bit cyl_ok(logic [11:0] b);  return b[9:0]  <= 10'd822; endfunction
    function automatic bit head_ok(logic [11:0] b); return b[11:8] <= 4'd8;    endfunction
    function automatic bit sec_ok(logic [11:0] b);  return b[7:0]  <= 8'd63;   endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cyl = '0; m_head = '0; m_sec = '0; m_flg = '0;
        p_seek = 0; p_adr = 0; p_xms = 0; p_cps = 0;
    endtask

    // Advance one clock: update the reference at the edge, compare at negedge
    task automatic tick();
        bit sr, ar, xr, cr, hard;
        @(posedge clk);
        if (!rst_n) model_reset();
        else begin
            sr = seek_cmd & ~p_seek; ar = adr_cmd & ~p_adr;
            xr = xms_cmd & ~p_xms;   cr = cps_cmd & ~p_cps;
            hard = por_start | run_on | cr;
            if (sr && cyl_ok(bus_data)) m_cyl = bus_data[9:0];
            if (ar && head_ok(bus_data)) m_head = bus_data[11:8];
            if ((ar | xr) && sec_ok(bus_data)) m_sec = bus_data[7:0];
            if (hard || home_cmd) m_flg[0] = 0;
            else if (sr && (!cyl_ok(bus_data) || !access_ready)) m_flg[0] = 1;
            else if (sr) m_flg[0] = 0;
            if (hard) m_flg[1] = 0; else if (ar && !head_ok(bus_data)) m_flg[1] = 1;
            if (hard) m_flg[2] = 0; else if ((ar | xr) && !sec_ok(bus_data)) m_flg[2] = 1;
            p_seek = seek_cmd; p_adr = adr_cmd; p_xms = xms_cmd; p_cps = cps_cmd;
        end
        @(negedge clk);
        chk("R2 cyl_addr", 32'(cyl_addr), 32'(m_cyl));
        chk("R6 head_addr", 32'(head_addr), 32'(m_head));
        chk("R7 sector_addr", 32'(sector_addr), 32'(m_sec));
        chk("R11 fault_flags", 32'(fault_flags), 32'(m_flg));
    endtask

    task automatic idle();
        seek_cmd = 0; adr_cmd = 0; xms_cmd = 0; cps_cmd = 0;
        home_cmd = 0; por_start = 0; run_on = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        rst_n = 0; bus_data = '0; access_ready = 1; idle();
        model_reset();
        tick(); tick();
        rst_n = 1;
        tick();
        chk("R1 reset cyl", 32'(cyl_addr), 0);
        chk("R1 reset flags", 32'(fault_flags), 0);

        // R2 boundary legal 822
        bus_data = 12'd822; seek_cmd = 1; tick();
        chk("R2 cyl 822 loaded", 32'(cyl_addr), 822);
        chk("R5 legal seek no flag", 32'(fault_flags[0]), 0);
        seek_cmd = 0; tick();
        // R3 boundary illegal 823
        bus_data = 12'd823; seek_cmd = 1; tick();
        chk("R2 cyl 823 blocked", 32'(cyl_addr), 822);
        chk("R3 seek check set", 32'(fault_flags[0]), 1);
        // R10 held strobe, bus changes
        bus_data = 12'd100; tick(); tick();
        chk("R10 held seek no load", 32'(cyl_addr), 822);
        seek_cmd = 0; tick();
        // R5 legal seek with ready clears
        seek_cmd = 1; tick();
        chk("R5 legal seek clears", 32'(fault_flags[0]), 0);
        chk("R2 cyl 100 loaded", 32'(cyl_addr), 100);
        seek_cmd = 0; tick();
        // R4 busy seek
        bus_data = 12'd200; access_ready = 0; seek_cmd = 1; tick();
        chk("R4 busy seek flags", 32'(fault_flags[0]), 1);
        chk("R4 busy legal cyl loads", 32'(cyl_addr), 200);
        seek_cmd = 0; access_ready = 1; tick();
        home_cmd = 1; tick();
        chk("R5 home clears", 32'(fault_flags[0]), 0);
        home_cmd = 0; tick();
        // R6/R7 illegal head 9 sector 64
        bus_data = {4'd9, 8'd64}; adr_cmd = 1; tick();
        chk("R6 head 9 blocked", 32'(head_addr), 0);
        chk("R7 sector 64 blocked", 32'(sector_addr), 0);
        chk("R11 flag order", 32'(fault_flags), 3'b110);
        adr_cmd = 0; tick();
        // R8 legal boundary values load, flags persist
        bus_data = {4'd8, 8'd63}; adr_cmd = 1; tick();
        chk("R6 head 8 loaded", 32'(head_addr), 8);
        chk("R7 sector 63 loaded", 32'(sector_addr), 63);
        chk("R8 flags sticky", 32'(fault_flags), 3'b110);
        adr_cmd = 0; tick();
        // R7 xms leaves head alone
        bus_data = {4'd3, 8'd5}; xms_cmd = 1; tick();
        chk("R7 xms sector", 32'(sector_addr), 5);
        chk("R7 xms head kept", 32'(head_addr), 8);
        xms_cmd = 0; tick();
        // R9 cps clear together with illegal adr
        bus_data = {4'd12, 8'd200}; adr_cmd = 1; cps_cmd = 1; tick();
        chk("R9 cps beats set", 32'(fault_flags), 0);
        idle(); tick();
        // R9 run beats illegal seek
        bus_data = 12'd1000; seek_cmd = 1; run_on = 1; tick();
        chk("R9 run beats seek set", 32'(fault_flags[0]), 0);
        idle(); tick();
        // R8 por clears sticky flags
        bus_data = {4'd15, 8'd99}; adr_cmd = 1; tick();
        adr_cmd = 0; por_start = 1; tick();
        chk("R8 por clears", 32'(fault_flags), 0);
        idle(); tick();

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic [9:0] c; logic [3:0] h; logic [7:0] s;
            c = ($urandom_range(0, 3) == 0) ? 10'($urandom_range(815, 830))
                                              : 10'($urandom_range(0, 1023));
            h = 4'($urandom_range(0, 15));
            s = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(56, 71))
                                              : 8'($urandom_range(0, 255));
            bus_data     = $urandom_range(0, 1) ? {h, s} : {2'b00, c};
            seek_cmd     = ($urandom_range(0, 2) == 0);
            adr_cmd      = ($urandom_range(0, 2) == 0);
            xms_cmd      = ($urandom_range(0, 3) == 0);
            cps_cmd      = ($urandom_range(0, 19) == 0);
            home_cmd     = ($urandom_range(0, 11) == 0);
            por_start    = ($urandom_range(0, 39) == 0);
            run_on       = ($urandom_range(0, 39) == 0);
            access_ready = ($urandom_range(0, 3) != 0);
            tick();
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule